// File: doc/BRIEF.md
# Two-Port Output-Enable Register with Set/Clear/Toggle Aliases

This block keeps a small direction-control word that decides, line by line, whether each of six controlled lines is driven as an output (bit = 1) or left as an input (bit = 0). Two processor ports can reach the word, and both may write in the same clock cycle. Each port sees the same four-word address window:

- a plain location, where a write replaces the value;
- three alias locations that change the stored value in one cycle, without a read-modify-write from the processor: one sets bits, one clears bits and one inverts bits.

When both ports write in the same cycle, the block combines the two operations in a fixed order. The port 0 operation is applied to the stored value first, and the port 1 operation is then applied to that intermediate result. Each write takes one cycle and never stalls. The stored word drives the output-enable vector directly. Either port can read the word back from any of the four window addresses.

Top module: `oe_alias_reg`

## Requirements
- R1: While reset is high and at the first edge after it, the stored value is zero, so `oe` is all zeros and every line is an input.
- R2: A write to byte address 0x040 replaces the stored 6-bit value with wdata[5:0]. Bits 31:6 of wdata are ignored.
- R3: A write to byte address 0x044 leaves the stored value equal to the old value OR wdata[5:0].
- R4: A write to byte address 0x048 leaves the stored value equal to the old value AND NOT wdata[5:0].
- R5: A write to byte address 0x04C leaves the stored value equal to the old value XOR wdata[5:0].
- R6: When both ports write in the same cycle, the port 0 operation is applied to the old value first, and the port 1 operation is applied to that result. This holds for any mix of the four addresses.
- R7: A write becomes visible on `oe` and on reads in the cycle after it is issued. A read in the same cycle as a write returns the value from before the write.
- R8: A read (valid=1, write=0) at any of the four window addresses returns the stored value in rdata[5:0], with rdata[31:6] zero, in the same cycle. A read does not change the stored value.
- R9: An access is ignored when valid is low, or when its address lies outside 0x040 to 0x04F, or when address bits 1:0 are not zero. Such an access leaves `oe` unchanged, and a port whose access is not a window read shows rdata = 0.
- R10: `oe[i]` equals stored bit i. A 1 means line i is driven as an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p0_valid | input | 1 | Port 0 access request |
| p0_write | input | 1 | Port 0: 1 = write, 0 = read |
| p0_addr | input | 12 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data |
| p1_valid | input | 1 | Port 1 access request |
| p1_write | input | 1 | Port 1: 1 = write, 0 = read |
| p1_addr | input | 12 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data |
| oe | output | 6 | Output-enable vector, 1 = drive |

## Verification
Two functions can fall in the same cycle:

- a port 0 write and a port 1 write, each going to any of the four aliases;
- a write on one port and a read on the other.

The bench provokes both, first with directed pairs such as set-then-clear, clear-then-set and a double toggle, and then with long random runs in which both ports are busy in most cycles. A reference model in the bench applies port 0 and then port 1 to its own copy of the value. On every clock the bench compares `oe` against the model, and it compares each read against the value from before the cycle's writes, so any reversed ordering or early visibility is reported.

// File: rtl/oe_alias_pkg.sv
package oe_alias_pkg;

    localparam int DATA_W = 32;
    localparam int LIVE_W = 6;
    localparam int ADDR_W = 12;
    localparam int N_PORT = 2;

    // Word index within the window selects the operation.
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_FLIP = 2'd3
    } op_e;

    typedef struct packed {
        logic              en;
        op_e               op;
        logic [LIVE_W-1:0] mask;
    } wr_req_t;

    function automatic logic [LIVE_W-1:0] apply_req(
        input logic [LIVE_W-1:0] cur,
        input wr_req_t           req
    );
        logic [LIVE_W-1:0] res;
        res = cur;
        if (req.en) begin
            unique case (req.op)
                OP_LOAD: res = req.mask;
                OP_SET:  res = cur | req.mask;
                OP_CLR:  res = cur & ~req.mask;
                OP_FLIP: res = cur ^ req.mask;
                default: res = cur;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/oe_port_decode.sv
module oe_port_decode
    import oe_alias_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 12'h040
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_req_t           req,
    output logic              rd_hit
);
    localparam int WIN_LSB = 4;

    logic in_win;
    logic unused_upper;

    assign in_win = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB])
                  && (addr[1:0] == 2'b00);
    assign unused_upper = ^wdata[DATA_W-1:LIVE_W];

    always_comb begin
        req.en   = valid && write && in_win;
        req.op   = op_e'(addr[3:2]);
        req.mask = wdata[LIVE_W-1:0];
    end

    assign rd_hit = valid && !write && in_win;

endmodule

// File: rtl/oe_alias_merge.sv
module oe_alias_merge
    import oe_alias_pkg::*;
(
    input  logic [LIVE_W-1:0] cur,
    input  wr_req_t           reqs [N_PORT],
    output logic [LIVE_W-1:0] nxt
);
    // Ordered chain: stage k applies port k to the result of stage k-1.
    logic [LIVE_W-1:0] stage [N_PORT+1];

    assign stage[0] = cur;

    for (genvar k = 0; k < N_PORT; k++) begin : g_chain
        assign stage[k+1] = apply_req(stage[k], reqs[k]);
    end

    assign nxt = stage[N_PORT];

endmodule

// File: rtl/oe_alias_reg.sv
module oe_alias_reg
    import oe_alias_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 12'h040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p0_valid,
    input  logic              p0_write,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_valid,
    input  logic              p1_write,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [LIVE_W-1:0] oe
);
    logic              v_a   [N_PORT];
    logic              w_a   [N_PORT];
    logic [ADDR_W-1:0] a_a   [N_PORT];
    logic [DATA_W-1:0] d_a   [N_PORT];
    logic [DATA_W-1:0] r_a   [N_PORT];
    wr_req_t           reqs  [N_PORT];
    logic              rhit  [N_PORT];

    logic [LIVE_W-1:0] val_q;
    logic [LIVE_W-1:0] val_d;

    assign v_a[0] = p0_valid;  assign v_a[1] = p1_valid;
    assign w_a[0] = p0_write;  assign w_a[1] = p1_write;
    assign a_a[0] = p0_addr;   assign a_a[1] = p1_addr;
    assign d_a[0] = p0_wdata;  assign d_a[1] = p1_wdata;
    assign p0_rdata = r_a[0];
    assign p1_rdata = r_a[1];

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        oe_port_decode #(.BASE(BASE)) u_dec (
            .valid  (v_a[p]),
            .write  (w_a[p]),
            .addr   (a_a[p]),
            .wdata  (d_a[p]),
            .req    (reqs[p]),
            .rd_hit (rhit[p])
        );
        assign r_a[p] = rhit[p] ? {{(DATA_W-LIVE_W){1'b0}}, val_q} : '0;
    end

    oe_alias_merge u_merge (
        .cur  (val_q),
        .reqs (reqs),
        .nxt  (val_d)
    );

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign oe = val_q;

endmodule

// File: rtl/oe_alias_chk.sv
module oe_alias_chk
    import oe_alias_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              p0_valid,
    input logic              p0_write,
    input logic [ADDR_W-1:0] p0_addr,
    input logic [DATA_W-1:0] p0_wdata,
    input logic [DATA_W-1:0] p0_rdata,
    input logic              p1_valid,
    input logic              p1_write,
    input logic [ADDR_W-1:0] p1_addr,
    input logic [DATA_W-1:0] p1_wdata,
    input logic [DATA_W-1:0] p1_rdata,
    input logic [LIVE_W-1:0] oe
);
    logic p0_set_only, p0_clr_only, p1_flip_only, both_load;

    assign p0_set_only  = p0_valid && p0_write && p0_addr == 12'h044 && !p1_valid;
    assign p0_clr_only  = p0_valid && p0_write && p0_addr == 12'h048 && !p1_valid;
    assign p1_flip_only = p1_valid && p1_write && p1_addr == 12'h04C && !p0_valid;
    assign both_load    = p0_valid && p0_write && p0_addr == 12'h040
                       && p1_valid && p1_write && p1_addr == 12'h040;

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> oe == '0);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!p0_valid && !p1_valid) |=> $stable(oe));

    a_r3_set_or: assert property (@(posedge clk) disable iff (rst)
        p0_set_only |=> oe == ($past(oe) | $past(p0_wdata[LIVE_W-1:0])));

    a_r4_clr_andn: assert property (@(posedge clk) disable iff (rst)
        p0_clr_only |=> oe == ($past(oe) & ~$past(p0_wdata[LIVE_W-1:0])));

    a_r5_flip_xor: assert property (@(posedge clk) disable iff (rst)
        p1_flip_only |=> oe == ($past(oe) ^ $past(p1_wdata[LIVE_W-1:0])));

    a_r6_port1_last: assert property (@(posedge clk) disable iff (rst)
        both_load |=> oe == $past(p1_wdata[LIVE_W-1:0]));

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        p0_rdata[DATA_W-1:LIVE_W] == '0 && p1_rdata[DATA_W-1:LIVE_W] == '0);

    a_r8_read_current: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && !p0_write && p0_addr == 12'h04C) |-> p0_rdata[LIVE_W-1:0] == oe);

endmodule

bind oe_alias_reg oe_alias_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .p0_valid (p0_valid),
    .p0_write (p0_write),
    .p0_addr  (p0_addr),
    .p0_wdata (p0_wdata),
    .p0_rdata (p0_rdata),
    .p1_valid (p1_valid),
    .p1_write (p1_write),
    .p1_addr  (p1_addr),
    .p1_wdata (p1_wdata),
    .p1_rdata (p1_rdata),
    .oe       (oe)
);

// File: tb/tb_oe_alias_reg.sv
module tb_oe_alias_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        p0_valid = 0, p0_write = 0, p1_valid = 0, p1_write = 0;
    logic [11:0] p0_addr = 0, p1_addr = 0;
    logic [31:0] p0_wdata = 0, p1_wdata = 0;
    logic [31:0] p0_rdata, p1_rdata;
    logic [5:0]  oe;

    int errors = 0;
    int checks = 0;
    int model  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oe_alias_reg dut (
        .clk(clk), .rst(rst),
        .p0_valid(p0_valid), .p0_write(p0_write), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_valid(p1_valid), .p1_write(p1_write), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .oe(oe)
    );

    function automatic bit in_win(input int a);
        return (a >= 'h40) && (a <= 'h4F) && ((a & 3) == 0);
    endfunction

    function automatic int ref_op(input int cur, input int a, input int d);
        int m;
        m = d & 'h3F;
        case ((a >> 2) & 3)
            0: return m;
            1: return cur | m;
            2: return cur & ~m & 'h3F;
            default: return (cur ^ m) & 'h3F;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check reads before the edge, check oe after it.
    task automatic cyc(input bit v0, input bit w0, input int a0, input int d0,
                       input bit v1, input bit w1, input int a1, input int d1,
                       input string tag);
        int e0, e1;
        p0_valid = v0; p0_write = w0; p0_addr = a0[11:0]; p0_wdata = d0;
        p1_valid = v1; p1_write = w1; p1_addr = a1[11:0]; p1_wdata = d1;
        #1;
        e0 = (v0 && !w0 && in_win(a0)) ? model : 0;
        e1 = (v1 && !w1 && in_win(a1)) ? model : 0;
        check({tag, " R8/R9 rdata0"}, p0_rdata, e0);
        check({tag, " R8/R9 rdata1"}, p1_rdata, e1);
        if (v0 && w0 && in_win(a0)) model = ref_op(model, a0, d0);
        if (v1 && w1 && in_win(a1)) model = ref_op(model, a1, d1);
        @(posedge clk); #1;
        check({tag, " R7/R10 oe"}, oe, model);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int addrs[8] = '{'h40, 'h44, 'h48, 'h4C, 'h50, 'h3C, 'h42, 'h140};
        repeat (3) @(negedge clk);
        check("R1 reset oe", oe, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset oe", oe, 0);

        // R2 plain write, upper wdata ignored
        cyc(1,1,'h40,'hFFFF_FFE5, 0,0,0,0, "R2 load");
        cyc(1,0,'h40,0, 1,0,'h44,0, "R8 read aliases");
        // R3 / R4 / R5
        cyc(0,0,0,0, 1,1,'h44,'h0A, "R3 set");
        cyc(1,1,'h48,'h21, 0,0,0,0, "R4 clr");
        cyc(1,1,'h4C,'h3F, 0,0,0,0, "R5 xor");
        cyc(1,0,'h48,0, 1,0,'h4C,0, "R8 read clr/xor addr");
        // R7 read during write sees old value
        cyc(1,1,'h40,'h15, 1,0,'h40,0, "R7 read-during-write");
        cyc(0,0,0,0, 1,0,'h40,0, "R7 read after write");
        // R6 ordering
        cyc(1,1,'h44,'h3C, 1,1,'h48,'h0C, "R6 set then clr");
        cyc(1,1,'h48,'h3F, 1,1,'h44,'h01, "R6 clr then set");
        cyc(1,1,'h4C,'h07, 1,1,'h4C,'h05, "R6 double xor");
        cyc(1,1,'h40,'h2A, 1,1,'h40,'h11, "R6 both load");
        cyc(1,1,'h40,'h00, 1,1,'h4C,'h3F, "R6 load then xor");
        // R9 ignored accesses
        cyc(1,1,'h50,'h00, 1,1,'h3C,'h00, "R9 out of window");
        cyc(1,1,'h42,'h00, 0,1,'h40,'h00, "R9 misaligned/invalid");
        cyc(1,0,'h50,0, 1,0,'h41,0, "R9 read outside");
        cyc(1,1,'h140,'h00, 0,0,0,0, "R9 high address");

        for (int i = 0; i < 3000; i++) begin
            cyc($urandom_range(0,3) != 0, $urandom_range(0,1), addrs[$urandom_range(0,7)], $urandom,
                $urandom_range(0,3) != 0, $urandom_range(0,1), addrs[$urandom_range(0,7)], $urandom,
                "R6 random");
        end

        // R1 reset mid-run
        p0_valid = 0; p1_valid = 0;
        rst = 1; @(posedge clk); #1;
        check("R1 reset mid-run", oe, 0);
        rst = 0; model = 0;
        @(negedge clk);
        cyc(1,0,'h44,0, 0,0,0,0, "R1 read after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule